// File: doc/BRIEF.md
# SMBus ARP Target Transaction Classifier

This block sits after a byte-level SMBus target front end. It watches the start, repeated-start, byte and stop events of every bus transaction and sorts the transaction into one protocol class. The classes cover address resolution traffic (prepare, reset, get identifier, assign address), notification traffic aimed at the host address, and ordinary SMBus/I2C transactions directed at the device's own 7-bit address. The device's address, its 128-bit unique identifier and two configuration bits that control checking of the read/write bit are inputs.

The block does not answer on the bus. It counts byte positions, compares the address, command and identifier bytes as they arrive, and keeps the class it has chosen so far. The result is held back until the stop and is then presented as a one-cycle descriptor: a 4-bit protocol code and a match flag. The identifier is compared one byte at a time with a sticky mismatch flag, so no 128-bit capture register is needed.

Top module: `smbus_arp_classifier`

## Requirements
- R1: During and directly after reset, `desc_vld` and `desc_match` are 0 and `desc_code` is 0.
- R2: A stop that closes a transaction opened by a start or repeated start makes `desc_vld` high for exactly the one cycle after that stop. A stop with no open transaction produces no pulse. `desc_match` is 1 exactly when the pulsed code is not 0. While `desc_vld` is low, `desc_code` is 0 and `desc_match` is 0.
- R3: Address byte C2h followed by command 01h gives code 1 (prepare). Command 02h gives code 2 (general reset). Command 03h gives code 3 (general get identifier).
- R4: Address C2h with command 04h gives code 4 (assign address) only if transaction bytes 3 to 18 (0-based, byte 0 is the address, byte 2 is a count that is ignored) equal the 128-bit identifier, most significant byte first. A single differing byte, or a stop before byte 18, gives code 0.
- R5: Address C2h with a command whose upper seven bits equal the own address gives code 5 (directed get identifier) when the command LSB is 1, and code 6 (directed reset) when it is 0. Commands 01h to 04h take priority over this.
- R6: Address 10h with command C2h gives code 7 (notify address-resolution master). Address 10h with any other command gives code 8 (host notify).
- R7: An address byte whose upper seven bits equal the own address gives code 9 (quick command) when the stop comes right after it, and code 10 (ordinary) when at least one more byte follows. Any other address gives code 0. Address priority is C2h, then 10h, then the own address.
- R8: A repeated start after a transaction already classed 3 or 5 keeps that class if the next address byte is C3h. After class 10, a repeated-start address {own address, 1} gives code 11 (block read). Any other repeated-start address, or a stop with no byte after the repeated start, gives code 0. Bytes after these are ignored.
- R9: When `chk_rw_start` is 1, the start address byte must have LSB 0 to be recognised as C2h, 10h or the own address. When it is 0, C3h, 11h and {own, 1} are accepted in the same way.
- R10: When `chk_rw_rstart` is 1, the repeated-start address byte must have LSB 1 (C3h, {own, 1}). When it is 0, C2h and {own, 0} are also accepted.
- R11: A start in mid-transaction, or a repeated start in any other situation than R8 (no qualifying class, or a second repeated start), discards the partial transaction and its identifier compare. The next byte is then taken as a start address.
- R12: Events in the same cycle are handled in this order: start or repeated start, then the byte, then the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition seen |
| ev_rstart | input | 1 | Repeated-start condition seen |
| ev_byte_vld | input | 1 | `ev_byte` holds a received byte |
| ev_byte | input | 8 | Received byte |
| ev_stop | input | 1 | Stop condition seen |
| own_addr | input | 7 | Device's own target address |
| own_udid | input | 128 | Device's unique identifier |
| chk_rw_start | input | 1 | Enable R/W LSB check on start address |
| chk_rw_rstart | input | 1 | Enable R/W LSB check on repeated-start address |
| desc_vld | output | 1 | Descriptor pulse, cycle after stop |
| desc_code | output | 4 | Protocol class code |
| desc_match | output | 1 | Transaction claimed (code not 0) |

## Verification
Two things can fall in the same cycle: the last identifier byte together with the stop, and a start together with the address byte. In the first case, the closing decision must take in the comparison of that same byte. In the second case, the start must clear the old state before the address is decoded. The bench drives both combinations, along with stops straight after a repeated start. A behavioural model in the bench rebuilds each transaction from byte queues and classifies it only at the stop. Its code is compared with the outputs every cycle, and explicit checks compare the outputs against literal codes.

// File: rtl/smbus_arp_pkg.sv
package smbus_arp_pkg;

   typedef enum logic [3:0] {
      P_NONE        = 4'd0,
      P_PREP        = 4'd1,
      P_RST_GEN     = 4'd2,
      P_GUD_GEN     = 4'd3,
      P_ASSIGN      = 4'd4,
      P_GUD_DIR     = 4'd5,
      P_RST_DIR     = 4'd6,
      P_NOTIFY_ARP  = 4'd7,
      P_HOST_NOTIFY = 4'd8,
      P_QUICK       = 4'd9,
      P_ORDINARY    = 4'd10,
      P_BLOCK_READ  = 4'd11
   } proto_e;

   typedef enum logic [1:0] {
      K_NONE,
      K_ARP,
      K_NOTIFY,
      K_OWN
   } kind_e;

   localparam logic [7:0] CMD_PREP   = 8'h01;
   localparam logic [7:0] CMD_RST    = 8'h02;
   localparam logic [7:0] CMD_GUD    = 8'h03;
   localparam logic [7:0] CMD_ASSIGN = 8'h04;

endpackage

// File: rtl/sac_addr_match.sv
module sac_addr_match
   import smbus_arp_pkg::*;
#(
   parameter int          ADDR_W      = 7,
   parameter logic [7:0]  ARP_ADDR    = 8'hC2,
   parameter logic [7:0]  NOTIFY_ADDR = 8'h10
) (
   input  logic [7:0]        byte_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              chk_start_i,
   input  logic              chk_rstart_i,
   output kind_e             kind_o,
   output logic              rs_arp_ok_o,
   output logic              rs_own_ok_o
);

   if (ADDR_W != 7) begin : g_bad_addr_w
      $error("sac_addr_match: ADDR_W must be 7");
   end

   logic lsb_ok_st;
   logic lsb_ok_rs;
   logic hit_arp;
   logic hit_ntf;
   logic hit_own;

   assign lsb_ok_st = !chk_start_i  || !byte_i[0];
   assign lsb_ok_rs = !chk_rstart_i ||  byte_i[0];

   assign hit_arp = (byte_i[7:1] == ARP_ADDR[7:1]);
   assign hit_ntf = (byte_i[7:1] == NOTIFY_ADDR[7:1]);
   assign hit_own = (byte_i[7:1] == own_addr_i);

   always_comb begin
      kind_o = K_NONE;
      if (hit_arp && lsb_ok_st)      kind_o = K_ARP;
      else if (hit_ntf && lsb_ok_st) kind_o = K_NOTIFY;
      else if (hit_own && lsb_ok_st) kind_o = K_OWN;
   end

   assign rs_arp_ok_o = hit_arp && lsb_ok_rs;
   assign rs_own_ok_o = hit_own && lsb_ok_rs;

endmodule

// File: rtl/sac_cmd_decode.sv
module sac_cmd_decode
   import smbus_arp_pkg::*;
#(
   parameter int          ADDR_W   = 7,
   parameter logic [7:0]  ARP_ADDR = 8'hC2
) (
   input  kind_e             kind_i,
   input  logic [7:0]        cmd_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   output proto_e            proto_o
);

   always_comb begin
      proto_o = P_NONE;
      unique case (kind_i)
         K_ARP: begin
            if (cmd_i == CMD_PREP)                proto_o = P_PREP;
            else if (cmd_i == CMD_RST)            proto_o = P_RST_GEN;
            else if (cmd_i == CMD_GUD)            proto_o = P_GUD_GEN;
            else if (cmd_i == CMD_ASSIGN)         proto_o = P_ASSIGN;
            else if (cmd_i[7:1] == own_addr_i)    proto_o = cmd_i[0] ? P_GUD_DIR : P_RST_DIR;
         end
         K_NOTIFY: proto_o = (cmd_i == ARP_ADDR) ? P_NOTIFY_ARP : P_HOST_NOTIFY;
         K_OWN:    proto_o = P_ORDINARY;
         default:  proto_o = P_NONE;
      endcase
   end

endmodule

// File: rtl/sac_udid_cmp.sv
module sac_udid_cmp #(
   parameter int UDID_BYTES = 16,
   parameter int UDID_OFS   = 3,
   parameter int CNT_W      = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    en_i,
   input  logic [CNT_W-1:0]        idx_i,
   input  logic [7:0]              byte_i,
   input  logic [UDID_BYTES*8-1:0] udid_i,
   output logic                    bad_o,
   output logic                    bad_nx_o
);

   localparam int UDID_W = UDID_BYTES * 8;
   localparam int SEL_W  = $clog2(UDID_BYTES);
   localparam int WIN_HI = UDID_OFS + UDID_BYTES;

   if (UDID_BYTES < 2) begin : g_bad_bytes
      $error("sac_udid_cmp: UDID_BYTES must be at least 2");
   end
   if ((1 << CNT_W) <= WIN_HI) begin : g_bad_cnt
      $error("sac_udid_cmp: CNT_W too narrow for window");
   end

   logic [7:0] ref_b [UDID_BYTES];

   for (genvar k = 0; k < UDID_BYTES; k++) begin : g_ref
      assign ref_b[k] = udid_i[UDID_W-1-8*k -: 8];
   end

   logic             in_win;
   logic [CNT_W-1:0] rel;
   logic [SEL_W-1:0] sel;
   logic             bad_q;

   assign in_win = (idx_i >= CNT_W'(UDID_OFS)) && (idx_i < CNT_W'(WIN_HI));
   assign rel    = idx_i - CNT_W'(UDID_OFS);
   assign sel    = rel[SEL_W-1:0];

   always_comb begin
      bad_nx_o = clr_i ? 1'b0 : bad_q;
      if (en_i && in_win && (byte_i != ref_b[sel])) bad_nx_o = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bad_q <= 1'b0;
      else        bad_q <= bad_nx_o;
   end

   assign bad_o = bad_q;

   // R4
   sticky_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_q && !clr_i) |=> bad_q);

endmodule

// File: rtl/smbus_arp_classifier.sv
module smbus_arp_classifier
   import smbus_arp_pkg::*;
#(
   parameter int          ADDR_W      = 7,
   parameter int          UDID_BYTES  = 16,
   parameter int          UDID_OFS    = 3,
   parameter logic [7:0]  ARP_ADDR    = 8'hC2,
   parameter logic [7:0]  NOTIFY_ADDR = 8'h10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ev_start,
   input  logic                    ev_rstart,
   input  logic                    ev_byte_vld,
   input  logic [7:0]              ev_byte,
   input  logic                    ev_stop,
   input  logic [ADDR_W-1:0]       own_addr,
   input  logic [UDID_BYTES*8-1:0] own_udid,
   input  logic                    chk_rw_start,
   input  logic                    chk_rw_rstart,
   output logic                    desc_vld,
   output logic [3:0]              desc_code,
   output logic                    desc_match
);

   localparam int CNT_MAX = UDID_OFS + UDID_BYTES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (UDID_OFS < 2) begin : g_bad_ofs
      $error("smbus_arp_classifier: UDID_OFS must leave room for address and command");
   end

   // state
   logic             act_q, act_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   kind_e            kind_q, kind_n;
   proto_e           cls_q, cls_n;
   logic             rd_q, rd_n;
   logic             rds_q, rds_n;
   logic             vld_q, vld_n;
   proto_e           code_q, code_n;
   logic             match_q;

   // decoders
   kind_e  kind_w;
   logic   rs_arp_ok;
   logic   rs_own_ok;
   proto_e cmd_proto;

   sac_addr_match #(
      .ADDR_W      (ADDR_W),
      .ARP_ADDR    (ARP_ADDR),
      .NOTIFY_ADDR (NOTIFY_ADDR)
   ) i_addr (
      .byte_i       (ev_byte),
      .own_addr_i   (own_addr),
      .chk_start_i  (chk_rw_start),
      .chk_rstart_i (chk_rw_rstart),
      .kind_o       (kind_w),
      .rs_arp_ok_o  (rs_arp_ok),
      .rs_own_ok_o  (rs_own_ok)
   );

   sac_cmd_decode #(
      .ADDR_W   (ADDR_W),
      .ARP_ADDR (ARP_ADDR)
   ) i_cmd (
      .kind_i     (kind_q),
      .cmd_i      (ev_byte),
      .own_addr_i (own_addr),
      .proto_o    (cmd_proto)
   );

   // effective state after start / repeated start of this cycle
   logic             rs_expect;
   logic             restart;
   logic             act_eff;
   logic             rd_eff;
   logic [CNT_W-1:0] cnt_eff;
   logic             ud_en;
   logic             ud_bad_q;
   logic             ud_bad_nx;

   assign rs_expect = act_q && !rd_q &&
                      ((cls_q == P_GUD_GEN) || (cls_q == P_GUD_DIR) || (cls_q == P_ORDINARY));
   assign restart   = ev_start || (ev_rstart && !rs_expect);
   assign act_eff   = act_q || restart;
   assign rd_eff    = restart ? 1'b0 : (rd_q || ev_rstart);
   assign cnt_eff   = restart ? '0 : cnt_q;
   assign ud_en     = ev_byte_vld && act_eff && !rd_eff;

   sac_udid_cmp #(
      .UDID_BYTES (UDID_BYTES),
      .UDID_OFS   (UDID_OFS),
      .CNT_W      (CNT_W)
   ) i_udid (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (restart),
      .en_i     (ud_en),
      .idx_i    (cnt_eff),
      .byte_i   (ev_byte),
      .udid_i   (own_udid),
      .bad_o    (ud_bad_q),
      .bad_nx_o (ud_bad_nx)
   );

   always_comb begin
      act_n  = act_q;
      cnt_n  = cnt_q;
      kind_n = kind_q;
      cls_n  = cls_q;
      rd_n   = rd_q;
      rds_n  = rds_q;
      vld_n  = 1'b0;
      code_n = P_NONE;

      // step 1: start or repeated start
      if (restart) begin
         act_n  = 1'b1;
         cnt_n  = '0;
         kind_n = K_NONE;
         cls_n  = P_NONE;
         rd_n   = 1'b0;
         rds_n  = 1'b0;
      end else if (ev_rstart) begin
         rd_n  = 1'b1;
         rds_n = 1'b0;
      end

      // step 2: byte
      if (ev_byte_vld && act_n) begin
         if (rd_n) begin
            if (!rds_n) begin
               rds_n = 1'b1;
               if (cls_n == P_ORDINARY) cls_n = rs_own_ok ? P_BLOCK_READ : P_NONE;
               else if (!rs_arp_ok)     cls_n = P_NONE;
            end
         end else begin
            if (cnt_n == '0) begin
               kind_n = kind_w;
               cls_n  = (kind_w == K_OWN) ? P_QUICK : P_NONE;
            end else if (cnt_n == CNT_W'(1)) begin
               cls_n = cmd_proto;
            end
            if (cnt_n != CNT_W'(CNT_MAX)) cnt_n = cnt_n + CNT_W'(1);
         end
      end

      // step 3: stop
      if (ev_stop && act_n) begin
         vld_n  = 1'b1;
         act_n  = 1'b0;
         code_n = cls_n;
         if (rd_n && !rds_n) code_n = P_NONE;
         if ((cls_n == P_ASSIGN) && ((cnt_n != CNT_W'(CNT_MAX)) || ud_bad_nx)) code_n = P_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         cnt_q   <= '0;
         kind_q  <= K_NONE;
         cls_q   <= P_NONE;
         rd_q    <= 1'b0;
         rds_q   <= 1'b0;
         vld_q   <= 1'b0;
         code_q  <= P_NONE;
         match_q <= 1'b0;
      end else begin
         act_q   <= act_n;
         cnt_q   <= cnt_n;
         kind_q  <= kind_n;
         cls_q   <= cls_n;
         rd_q    <= rd_n;
         rds_q   <= rds_n;
         vld_q   <= vld_n;
         code_q  <= code_n;
         match_q <= vld_n && (code_n != P_NONE);
      end
   end

   assign desc_vld   = vld_q;
   assign desc_code  = code_q;
   assign desc_match = match_q;

   // R2
   desc_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_vld |-> $past(ev_stop));

   // R2
   match_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_match |-> (desc_vld && (desc_code != 4'd0)));

   // R8
   read_phase_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q |-> (cls_q inside {P_NONE, P_GUD_GEN, P_GUD_DIR, P_ORDINARY, P_BLOCK_READ}));

   // R11
   start_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && !ev_byte_vld) |=> (cnt_q == '0));

   // R4
   ud_unused_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ud_bad_q && !restart) |-> ud_bad_nx);

endmodule

// File: tb/test_smbus_arp_classifier.sv
`timescale 1ns/1ps
module test_smbus_arp_classifier;

   localparam logic [6:0]   OWN  = 7'h3A;
   localparam logic [127:0] UDID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_start = 1'b0, ev_rstart = 1'b0, ev_byte_vld = 1'b0, ev_stop = 1'b0;
   logic [7:0]  ev_byte = 8'h00;
   logic        cs = 1'b0, cr = 1'b0;
   logic        desc_vld, desc_match;
   logic [3:0]  desc_code;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #2 clk = ~clk;

   smbus_arp_classifier i_smbus_arp_classifier (
      .clk (clk), .rst_n (rst_n),
      .ev_start (ev_start), .ev_rstart (ev_rstart), .ev_byte_vld (ev_byte_vld),
      .ev_byte (ev_byte), .ev_stop (ev_stop),
      .own_addr (OWN), .own_udid (UDID),
      .chk_rw_start (cs), .chk_rw_rstart (cr),
      .desc_vld (desc_vld), .desc_code (desc_code), .desc_match (desc_match)
   );

   // ---------------- reference model ----------------
   logic [7:0] seg_a[$];
   logic [7:0] seg_b[$];
   bit m_act = 0, m_rd = 0;
   bit exp_vld = 0;
   int exp_code = 0;

   function automatic int classify();
      logic [7:0] a, c, b;
      int k, base;
      if (seg_a.size() == 0) return 0;
      a = seg_a[0];
      if (a == 8'hC2 || (!cs && a == 8'hC3))              k = 1;
      else if (a == 8'h10 || (!cs && a == 8'h11))         k = 2;
      else if (a[7:1] == OWN && (!cs || a[0] == 1'b0))    k = 3;
      else                                                k = 0;
      if (seg_a.size() == 1) base = (k == 3) ? 9 : 0;
      else begin
         c = seg_a[1];
         base = 0;
         if (k == 1) begin
            if (c == 8'h01) base = 1;
            else if (c == 8'h02) base = 2;
            else if (c == 8'h03) base = 3;
            else if (c == 8'h04) begin
               base = (seg_a.size() >= 19) ? 4 : 0;
               for (int i = 0; i < 16 && base == 4; i++)
                  if (seg_a[3+i] != UDID[127-8*i -: 8]) base = 0;
            end
            else if (c == {OWN, 1'b1}) base = 5;
            else if (c == {OWN, 1'b0}) base = 6;
         end
         else if (k == 2) base = (c == 8'hC2) ? 7 : 8;
         else if (k == 3) base = 10;
      end
      if (!m_rd) return base;
      if (seg_b.size() == 0) return 0;
      b = seg_b[0];
      if (base == 10) return (b[7:1] == OWN && (b[0] || !cr)) ? 11 : 0;
      return (b == 8'hC3 || (!cr && b == 8'hC2)) ? base : 0;
   endfunction

   always @(posedge clk) begin
      int c;
      exp_vld  = 0;
      exp_code = 0;
      if (!rst_n) begin
         m_act = 0; m_rd = 0; seg_a.delete(); seg_b.delete();
      end else begin
         if (ev_start) begin
            m_act = 1; m_rd = 0; seg_a.delete(); seg_b.delete();
         end else if (ev_rstart) begin
            c = classify();
            if (m_act && !m_rd && (c == 3 || c == 5 || c == 10)) begin
               m_rd = 1; seg_b.delete();
            end else begin
               m_act = 1; m_rd = 0; seg_a.delete(); seg_b.delete();
            end
         end
         if (ev_byte_vld && m_act) begin
            if (m_rd) seg_b.push_back(ev_byte);
            else      seg_a.push_back(ev_byte);
         end
         if (ev_stop && m_act) begin
            exp_vld  = 1;
            exp_code = classify();
            m_act    = 0;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (desc_vld !== exp_vld || desc_code !== 4'(exp_code) ||
             desc_match !== (exp_vld && exp_code != 0)) begin
            errors++;
            $display("FAIL %s model: vld=%0b code=%0d match=%0b expected vld=%0b code=%0d",
                     cur_req, desc_vld, desc_code, desc_match, exp_vld, exp_code);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input logic st, input logic rs, input logic bv,
                      input logic [7:0] b, input logic sp);
      @(negedge clk);
      ev_start = st; ev_rstart = rs; ev_byte_vld = bv; ev_byte = b; ev_stop = sp;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 8'h00, 0);
   endtask

   // called right after the stop cycle was driven
   task automatic expect_desc(input string req, input int code);
      idle();
      checks++;
      if (desc_vld !== 1'b1 || desc_code !== 4'(code) || desc_match !== (code != 0)) begin
         errors++;
         $display("FAIL %s: vld=%0b code=%0d match=%0b expected vld=1 code=%0d",
                  req, desc_vld, desc_code, desc_match, code);
      end
   endtask

   task automatic txn(input string req, input logic [7:0] bs[$], input int code);
      cur_req = req;
      cyc(1, 0, 0, 8'h00, 0);
      foreach (bs[i]) cyc(0, 0, 1, bs[i], 0);
      cyc(0, 0, 0, 8'h00, 1);
      expect_desc(req, code);
      idle();
   endtask

   task automatic assign_txn(input string req, input int bad_at, input int nbytes, input int code);
      logic [7:0] q[$];
      q = '{8'hC2, 8'h04, 8'h11};
      for (int i = 0; i < nbytes; i++)
         q.push_back((i == bad_at) ? ~UDID[127-8*i -: 8] : UDID[127-8*i -: 8]);
      q.push_back(8'h5A);
      txn(req, q, code);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      checks++;   // R1 during reset
      if (desc_vld !== 1'b0 || desc_code !== 4'd0 || desc_match !== 1'b0) begin
         errors++;
         $display("FAIL R1: vld=%0b code=%0d match=%0b expected 0 0 0", desc_vld, desc_code, desc_match);
      end
      rst_n = 1'b1;
      idle();
      checks++;   // R1 after reset
      if (desc_vld !== 1'b0 || desc_code !== 4'd0) begin
         errors++;
         $display("FAIL R1: vld=%0b code=%0d expected 0 0", desc_vld, desc_code);
      end

      // R2: stop with no open transaction gives no pulse
      cur_req = "R2";
      cyc(0, 0, 0, 8'h00, 1);
      idle();
      checks++;
      if (desc_vld !== 1'b0) begin
         errors++;
         $display("FAIL R2: vld=%0b expected 0", desc_vld);
      end

      // R3
      txn("R3", '{8'hC2, 8'h01}, 1);
      txn("R3", '{8'hC2, 8'h02}, 2);
      txn("R3", '{8'hC2, 8'h03}, 3);
      // R2: pulse lasts one cycle only
      checks++;
      if (desc_vld !== 1'b0 || desc_code !== 4'd0) begin
         errors++;
         $display("FAIL R2: vld=%0b code=%0d expected 0 0", desc_vld, desc_code);
      end

      // R4
      assign_txn("R4", -1, 16, 4);
      assign_txn("R4", 7, 16, 0);
      assign_txn("R4", 15, 16, 0);
      assign_txn("R4", -1, 10, 0);
      // R4 + R12: last identifier byte in the stop cycle
      cur_req = "R12";
      cyc(1, 0, 0, 8'h00, 0);
      cyc(0, 0, 1, 8'hC2, 0);
      cyc(0, 0, 1, 8'h04, 0);
      cyc(0, 0, 1, 8'h11, 0);
      for (int i = 0; i < 15; i++) cyc(0, 0, 1, UDID[127-8*i -: 8], 0);
      cyc(0, 0, 1, UDID[7:0], 1);
      expect_desc("R12", 4);
      cyc(1, 0, 0, 8'h00, 0);
      cyc(0, 0, 1, 8'hC2, 0);
      cyc(0, 0, 1, 8'h04, 0);
      cyc(0, 0, 1, 8'h11, 0);
      for (int i = 0; i < 15; i++) cyc(0, 0, 1, UDID[127-8*i -: 8], 0);
      cyc(0, 0, 1, ~UDID[7:0], 1);
      expect_desc("R12", 0);

      // R5
      txn("R5", '{8'hC2, {OWN, 1'b1}}, 5);
      txn("R5", '{8'hC2, {OWN, 1'b0}}, 6);
      txn("R5", '{8'hC2, 8'h40}, 0);

      // R6
      txn("R6", '{8'h10, 8'hC2}, 7);
      txn("R6", '{8'h10, 8'h66, 8'h34, 8'h12}, 8);

      // R7
      txn("R7", '{{OWN, 1'b0}}, 9);
      txn("R7", '{{OWN, 1'b0}, 8'h05, 8'h66}, 10);
      txn("R7", '{8'h50, 8'h22}, 0);

      // R8: read phases
      cr = 1'b1;
      cur_req = "R8";
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 1, 8'h03, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC3, 0); cyc(0, 0, 1, 8'h11, 0);
      cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R8", 3);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 1, {OWN, 1'b1}, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC3, 0);
      cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R8", 5);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 1, 8'h05, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b1}, 0); cyc(0, 0, 1, 8'h02, 0);
      cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R8", 11);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 1, 8'h05, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R8", 0);

      // R10
      cur_req = "R10";
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 1, 8'h05, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R10", 0);
      cr = 1'b0;
      idle();
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 1, 8'h05, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R10", 11);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 1, 8'h03, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R10", 3);

      // R9
      cs = 1'b1;
      idle();
      txn("R9", '{8'hC3, 8'h01}, 0);
      txn("R9", '{8'h11, 8'hC2}, 0);
      txn("R9", '{{OWN, 1'b1}}, 0);
      txn("R9", '{8'hC2, 8'h01}, 1);
      cs = 1'b0;
      idle();
      txn("R9", '{8'hC3, 8'h01}, 1);
      txn("R9", '{8'h11, 8'hC2}, 7);
      txn("R9", '{{OWN, 1'b1}}, 9);

      // R11: restarts
      cur_req = "R11";
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 1, 8'h04, 0);
      cyc(0, 0, 1, 8'h11, 0); cyc(0, 0, 1, 8'h99, 0);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'h10, 0); cyc(0, 0, 1, 8'hC2, 0);
      cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R11", 7);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 1, 8'h01, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, {OWN, 1'b0}, 0); cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R11", 9);
      cyc(1, 0, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC2, 0); cyc(0, 0, 1, 8'h03, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, 8'hC3, 0);
      cyc(0, 1, 0, 8'h00, 0); cyc(0, 0, 1, 8'h10, 0); cyc(0, 0, 1, 8'h77, 0);
      cyc(0, 0, 0, 8'h00, 1);
      expect_desc("R11", 8);

      // R12: start together with address, command together with stop
      cur_req = "R12";
      cyc(1, 0, 1, 8'hC2, 0); cyc(0, 0, 1, 8'h01, 1);
      expect_desc("R12", 1);
      cyc(1, 0, 1, {OWN, 1'b0}, 1);
      expect_desc("R12", 9);

      repeat (3) idle();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule